// File: doc/BRIEF.md
# UART baud clock generator

This block produces the baud-rate clock enable for a UART. An 8-bit control register, read and written over a simple register bus, holds two settings. One is a base-clock source: the peripheral clock divided by 2, 8 or 32, or the rising edges of an external timer output. The other is a 5-bit divisor k that turns every k base-clock enables into one output pulse.

The whole block runs on the peripheral clock. A free-running prescaler counter and an edge detector on the synchronised timer input each produce single-cycle enables. The divider counts these enables and raises `baud_tick_o` for one cycle on every k-th enable. Divisor codes below 8 are prohibited, and a write that carries one is discarded. Taking the module enable low holds both counters at zero and blocks the output.

Top module: `baud_clk_gen`

## Requirements
- R1: After reset the register reads 8'h1F: base clock is the peripheral clock divided by 2, and k = 31. Once enabled, the first output pulse comes 62 cycles later.
- R2: The read-back layout is source select in bits 7:6, a zero in bit 5, and k in bits 4:0. Bit 5 is not stored and always reads 0.
- R3: Source select 00 makes the base clock one enable every 2 cycles, so output pulses are 2*k cycles apart.
- R4: Source select 01 makes the base clock one enable every 8 cycles, so output pulses are 8*k cycles apart.
- R5: Source select 10 makes the base clock one enable every 32 cycles, so output pulses are 32*k cycles apart.
- R6: Source select 11 makes each rising edge of `tmr_i` one base-clock enable, taken after a two-flop synchroniser. A timer input with period P cycles gives output pulses k*P cycles apart.
- R7: The output is a pulse one cycle wide, issued once per k base-clock enables, for every k from 8 to 31.
- R8: A write whose bits 4:0 are below 8 is discarded as a whole. The read-back and the pulse spacing stay as they were, and the counters are not restarted.
- R9: An accepted write restarts the prescaler and divider from zero. For sources 00 to 10, the first pulse is seen k*N cycles after the write edge, where N is 2, 8 or 32.
- R10: While `en_i` is low, no pulse is issued and both counters are held at zero. After `en_i` rises, the first pulse comes on the k*N-th enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; low holds the counters at zero |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read-back (setting in force) |
| tmr_i | input | 1 | External timer output, asynchronous |
| baud_tick_o | output | 1 | One-cycle baud clock enable |

## Verification
After an accepted write the prescaler restarts from zero. The output pulse is registered, so the first pulse is due exactly k*N cycles after the write edge, and every later pulse follows k*N cycles after the one before it. The bench drives its inputs on falling edges and counts falling edges until the pulse is seen, so the latency and spacing it measures are whole cycle counts, compared exactly against k*N. The synchroniser makes the timer path's first pulse uncertain by a couple of cycles, so for that source only the spacing of the second pulse is checked, against k*P. Rejected writes are checked twice: through the read-back in the very next cycle, and by measuring that the pulse spacing has not changed.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned DIV_W   = 5;
  localparam int unsigned DIV_MIN = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h1F;

  typedef enum logic [1:0] {
    SRC_DIV2  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_TIMER = 2'b11
  } src_sel_e;

  typedef struct packed {
    src_sel_e         src;
    logic             rsvd;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/baud_ctrl_reg.sv
module baud_ctrl_reg
  import baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              restart_o
);
  ctrl_t ctrl_q;
  logic  accept;

  assign accept    = we_i && (wdata_i[DIV_W-1:0] >= DIV_W'(DIV_MIN));
  assign restart_o = accept;
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
    end else if (accept) begin
      ctrl_q.src  <= src_sel_e'(wdata_i[7:6]);
      ctrl_q.rsvd <= 1'b0;
      ctrl_q.div  <= wdata_i[DIV_W-1:0];
    end
  end

  // R8
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[DIV_W-1:0] < DIV_W'(DIV_MIN)) |=> $stable(ctrl_q));

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (ctrl_q.div == $past(wdata_i[DIV_W-1:0])) &&
               (ctrl_q.src == src_sel_e'($past(wdata_i[7:6]))) && !ctrl_q.rsvd);

  // R8
  div_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.div >= DIV_W'(DIV_MIN));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int unsigned SH_A = 1,
  parameter int unsigned SH_B = 3,
  parameter int unsigned SH_C = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     restart_i,
  input  src_sel_e src_i,
  input  logic     tmr_i,
  output logic     tick_o
);
  localparam int unsigned CNT_W = SH_C;
  localparam int unsigned NTAP  = 3;
  localparam int unsigned SHIFTS [NTAP] = '{SH_A, SH_B, SH_C};

  logic [CNT_W-1:0] cnt_q;
  logic [NTAP-1:0]  tap;
  logic [1:0]       sync_q;
  logic             prev_q;
  logic             tmr_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // tap g fires when the low SHIFTS[g] bits are all ones
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap[g] = &cnt_q[SHIFTS[g]-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tmr_i};
      prev_q <= sync_q[1];
    end
  end

  assign tmr_edge = sync_q[1] & ~prev_q;

  always_comb begin
    unique case (src_i)
      SRC_DIV2:  tick_o = tap[0];
      SRC_DIV8:  tick_o = tap[1];
      SRC_DIV32: tick_o = tap[2];
      default:   tick_o = tmr_edge;
    endcase
    if (!en_i) tick_o = 1'b0;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i) |=> !tick_o);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             base_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             pulse_q;
  logic             last;

  assign last    = cnt_q >= DIV_W'(div_i - 1'b1);
  assign pulse_o = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!en_i || restart_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (base_tick_i) begin
      cnt_q   <= last ? '0 : cnt_q + 1'b1;
      pulse_q <= last;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_i);
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        tmr_i,
  output logic        baud_tick_o
);
  ctrl_t ctrl;
  logic  restart;
  logic  base_tick;

  baud_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .ctrl_o    (ctrl),
    .restart_o (restart)
  );

  baud_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (restart),
    .src_i     (ctrl.src),
    .tmr_i     (tmr_i),
    .tick_o    (base_tick)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .restart_i   (restart),
    .base_tick_i (base_tick),
    .div_i       (ctrl.div),
    .pulse_o     (baud_tick_o)
  );

  assign reg_rdata_o = ctrl;

  // R10
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !baud_tick_o);
endmodule

// File: tb/baud_clk_gen_test.sv
`timescale 1ns/1ps
module baud_clk_gen_test;
  localparam int TMR_P = 6;
  localparam int WAIT_MAX = 5000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       tmr_i = 1'b0;
  logic       baud_tick_o;

  int checks = 0;
  int errors = 0;
  bit tmr_run = 1'b0;
  int tmr_ph = 0;
  bit done = 1'b0;

  baud_clk_gen uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .tmr_i       (tmr_i),
    .baud_tick_o (baud_tick_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    if (tmr_run) begin
      tmr_ph = (tmr_ph + 1) % TMR_P;
      tmr_i  = (tmr_ph < TMR_P / 2);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we_i    = 1'b1;
    reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!baud_tick_o && n < WAIT_MAX);
  endtask

  function automatic int base_n(input int sel);
    case (sel)
      0: return 2;
      1: return 8;
      default: return 32;
    endcase
  endfunction

  task automatic t_reset();
    int n;
    check(reg_rdata_o == 8'h1F, "R1 reset value", reg_rdata_o, 8'h1F);
    for (int i = 0; i < 20; i++) begin
      step();
      if (baud_tick_o) check(1'b0, "R10 pulse while disabled", 1, 0);
    end
    en_i = 1'b1;
    wait_pulse(n);
    check(n == 62, "R1 first pulse after enable", n, 62);
    wait_pulse(n);
    check(n == 62, "R1 default spacing", n, 62);
  endtask

  task automatic t_sel(input int sel, input int k);
    int n;
    int exp;
    string req;
    exp = k * base_n(sel);
    req = (sel == 0) ? "R3" : (sel == 1) ? "R4" : "R5";
    wr({sel[1:0], 1'b0, k[4:0]});
    wait_pulse(n);
    check(n == exp, "R9 latency after write", n, exp);
    wait_pulse(n);
    check(n == exp, req, n, exp);
    step();
    check(!baud_tick_o, "R7 pulse width", int'(baud_tick_o), 0);
  endtask

  task automatic t_layout();
    wr(8'h29);
    check(reg_rdata_o == 8'h09, "R2 bit5 dropped", reg_rdata_o, 8'h09);
    wr(8'hBF);
    check(reg_rdata_o == 8'h9F, "R2 layout", reg_rdata_o, 8'h9F);
  endtask

  task automatic t_prohibited();
    int n;
    wr(8'h0A);
    wr(8'h85);
    check(reg_rdata_o == 8'h0A, "R8 write k=5 ignored", reg_rdata_o, 8'h0A);
    wr(8'h47);
    check(reg_rdata_o == 8'h0A, "R8 write k=7 ignored", reg_rdata_o, 8'h0A);
    wr(8'hC0);
    check(reg_rdata_o == 8'h0A, "R8 write k=0 ignored", reg_rdata_o, 8'h0A);
    wait_pulse(n);
    wait_pulse(n);
    check(n == 20, "R8 spacing unchanged", n, 20);
  endtask

  task automatic t_timer(input int k);
    int n;
    tmr_run = 1'b1;
    wr({2'b11, 1'b0, k[4:0]});
    wait_pulse(n);
    wait_pulse(n);
    check(n == k * TMR_P, "R6 timer source spacing", n, k * TMR_P);
    step();
    check(!baud_tick_o, "R7 pulse width timer", int'(baud_tick_o), 0);
  endtask

  task automatic t_enable();
    int n;
    tmr_run = 1'b0;
    tmr_i   = 1'b0;
    wr(8'h48);
    en_i = 1'b0;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (baud_tick_o) n++;
    end
    check(n == 0, "R10 no pulse while disabled", n, 0);
    en_i = 1'b1;
    wait_pulse(n);
    check(n == 64, "R10 restart after enable", n, 64);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    t_reset();
    t_sel(0, 8);
    t_sel(0, 9);
    t_sel(0, 31);
    t_sel(1, 8);
    t_sel(1, 9);
    t_sel(1, 31);
    t_sel(2, 8);
    t_sel(2, 9);
    t_sel(2, 31);
    t_layout();
    t_prohibited();
    t_timer(8);
    t_timer(9);
    t_enable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule